// File: doc/BRIEF.md
# Two-Line Encoder Step Decoder

This block watches two asynchronous encoder lines and turns their motion into single-cycle count strobes for a counter placed after it. Each line is first brought into the system clock domain through a flop chain. The block then compares each new sample pair with the pair taken one clock earlier. From that comparison it decides whether the step counts up, counts down, counts nothing, or is an illegal jump.

Three input styles are supported. In phase-shifted mode the two lines form a gray-coded pair, and a rate select picks whether every edge counts, only edges of line A count, or one edge per full cycle counts. In gated-pulse mode line A carries the pulses and line B acts as an enable. In split-pulse mode line A carries up pulses and line B carries down pulses. An invert input swaps the up and down strobes in every style. A jump in which both phase-shifted lines move in the same sample is treated as noise. It sets a sticky flag that stays set until software-side logic pulses a clear input.

Top module: `aqd_decoder`

## Requirements
- R1: After reset is released with both lines low, count_up, count_down and abnormal are all 0 and stay 0 while the lines stay idle.
- R2: With in_mode=0 (phase-shifted; in_mode=3 behaves the same) and rate_sel=2 or 3 (every edge), each sample in which exactly one line changes gives one strobe. With the pair written {A,B}, the order 00,10,11,01,00 counts up and the reverse order counts down.
- R3: With in_mode=0 and rate_sel=1 (A edges), only a change of line A counts. The direction follows R2, and a change of line B alone gives no strobe.
- R4: With in_mode=0 and rate_sel=0 (one per cycle), only a change of line A while line B is 0 counts. A rising edge of A gives up, a falling edge of A gives down.
- R5: In phase-shifted mode, a sample in which both lines change gives no strobe and sets abnormal. In the other modes abnormal is never set.
- R6: abnormal stays 1 until abn_clr is high at a clock edge. If a new illegal jump is seen in the same cycle as the clear, the set wins.
- R7: With in_mode=1 (gated pulse), a strobe is given only when line B is 1 in the new sample. With rate_sel=0, a rising edge of A gives count_up. With any other rate_sel, both edges of A give count_up.
- R8: With in_mode=2 (split pulse), a rising edge of A gives count_up and a rising edge of B gives count_down. Falling edges give nothing. Rising edges of both lines in the same sample cancel and give no strobe.
- R9: dir_inv=1 swaps count_up and count_down in every mode.
- R10: A line change set up before clock edge k produces its strobe in the cycle that follows edge k+2. The strobe is exactly one cycle wide for each decoded step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_a | input | 1 | Raw encoder line A (phase A, pulse, or up pulse) |
| line_b | input | 1 | Raw encoder line B (phase B, enable, or down pulse) |
| in_mode | input | 2 | 0/3 phase-shifted, 1 gated pulse, 2 split up/down pulse |
| rate_sel | input | 2 | 0 one per cycle, 1 A edges, 2/3 every edge |
| dir_inv | input | 1 | Swap the up and down strobes |
| abn_clr | input | 1 | Clears the sticky abnormal flag |
| count_up | output | 1 | One-cycle up strobe |
| count_down | output | 1 | One-cycle down strobe |
| abnormal | output | 1 | Sticky illegal-jump flag |

## Verification
The assertions assume that in_mode, rate_sel and dir_inv change only while the lines are at rest. They also assume that each line holds a value for at least two clocks, so that the synchronizer never skips a state. The stimulus keeps to this: it changes the configuration only between steps and holds every line pair for five clocks. Each of the sixteen old/new pairs is then presented to every mode, rate and polarity. Before each measured step the flag is cleared, so that every transition is judged on its own.

// File: rtl/aqd_pkg.sv
package aqd_pkg;

  typedef enum logic [1:0] {
    MODE_QUAD   = 2'd0,
    MODE_SINGLE = 2'd1,
    MODE_UPDN   = 2'd2,
    MODE_QUAD_B = 2'd3
  } in_mode_e;

  typedef enum logic [1:0] {
    RATE_X1  = 2'd0,
    RATE_X2  = 2'd1,
    RATE_X4  = 2'd2,
    RATE_X4B = 2'd3
  } rate_e;

  typedef struct packed {
    logic up;
    logic dn;
    logic abn;
  } step_evt_t;

  // pair layout: bit1 = line A, bit0 = line B
  function automatic step_evt_t quad_step(logic [1:0] p, logic [1:0] c, rate_e r);
    step_evt_t e;
    logic a_chg, b_chg, fwd, qual;
    e     = '0;
    a_chg = p[1] ^ c[1];
    b_chg = p[0] ^ c[0];
    fwd   = c[1] ^ p[0];
    qual  = 1'b0;
    if (a_chg && b_chg) begin
      e.abn = 1'b1;
    end else if (a_chg || b_chg) begin
      case (r)
        RATE_X1: qual = a_chg && !p[0];
        RATE_X2: qual = a_chg;
        default: qual = 1'b1;
      endcase
      e.up = qual && fwd;
      e.dn = qual && !fwd;
    end
    return e;
  endfunction

  function automatic step_evt_t single_step(logic [1:0] p, logic [1:0] c, rate_e r);
    step_evt_t e;
    logic rise, fall;
    e    = '0;
    rise = !p[1] && c[1];
    fall = p[1] && !c[1];
    e.up = c[0] && (rise || ((r != RATE_X1) && fall));
    return e;
  endfunction

  function automatic step_evt_t updn_step(logic [1:0] p, logic [1:0] c);
    step_evt_t e;
    logic ru, rd;
    e    = '0;
    ru   = !p[1] && c[1];
    rd   = !p[0] && c[0];
    e.up = ru && !rd;
    e.dn = rd && !ru;
    return e;
  endfunction

  function automatic step_evt_t apply_dir(step_evt_t e, logic inv);
    step_evt_t o;
    o     = e;
    o.up  = inv ? e.dn : e.up;
    o.dn  = inv ? e.up : e.dn;
    return o;
  endfunction

endpackage

// File: rtl/aqd_sync.sv
module aqd_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/aqd_step_decode.sv
module aqd_step_decode
  import aqd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic [1:0] cur,
  input  in_mode_e  mode,
  input  rate_e     rate,
  input  logic      inv,
  output step_evt_t evt
);
  logic [1:0] prev;
  step_evt_t  raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 2'b00;
    else        prev <= cur;
  end

  always_comb begin
    case (mode)
      MODE_SINGLE: raw = single_step(prev, cur, rate);
      MODE_UPDN:   raw = updn_step(prev, cur);
      default:     raw = quad_step(prev, cur, rate);
    endcase
    evt = apply_dir(raw, inv);
  end
endmodule

// File: rtl/aqd_out.sv
module aqd_out
  import aqd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  step_evt_t evt,
  input  logic      abn_clr,
  output logic      count_up,
  output logic      count_down,
  output logic      abnormal
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_up   <= 1'b0;
      count_down <= 1'b0;
      abnormal   <= 1'b0;
    end else begin
      count_up   <= evt.up;
      count_down <= evt.dn;
      if (evt.abn)      abnormal <= 1'b1;
      else if (abn_clr) abnormal <= 1'b0;
    end
  end
endmodule

// File: rtl/aqd_decoder.sv
module aqd_decoder
  import aqd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_a,
  input  logic       line_b,
  input  logic [1:0] in_mode,
  input  logic [1:0] rate_sel,
  input  logic       dir_inv,
  input  logic       abn_clr,
  output logic       count_up,
  output logic       count_down,
  output logic       abnormal
);
  localparam int LINES = 2;

  logic [LINES-1:0] pair_s;
  step_evt_t        evt;
  logic             evt_up, evt_dn, evt_abn;

  aqd_sync #(.STAGES(SYNC_STAGES), .WIDTH(LINES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({line_a, line_b}),
    .dout (pair_s)
  );

  aqd_step_decode u_dec (
    .clk  (clk),
    .rst_n(rst_n),
    .cur  (pair_s),
    .mode (in_mode_e'(in_mode)),
    .rate (rate_e'(rate_sel)),
    .inv  (dir_inv),
    .evt  (evt)
  );

  assign evt_up  = evt.up;
  assign evt_dn  = evt.dn;
  assign evt_abn = evt.abn;

  aqd_out u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt       (evt),
    .abn_clr   (abn_clr),
    .count_up  (count_up),
    .count_down(count_down),
    .abnormal  (abnormal)
  );
endmodule

// File: rtl/aqd_checker.sv
module aqd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] in_mode,
  input logic       abn_clr,
  input logic       evt_up,
  input logic       evt_dn,
  input logic       evt_abn,
  input logic       count_up,
  input logic       count_down,
  input logic       abnormal
);
  p_one_dir_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(count_up && count_down));

  p_abn_nocount_r5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_abn |=> (!count_up && !count_down));

  p_abn_quad_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_abn |-> (in_mode == 2'd0 || in_mode == 2'd3));

  p_abn_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_abn |=> abnormal);

  p_abn_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (abnormal && !abn_clr) |=> abnormal);

  p_abn_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (abn_clr && !evt_abn) |=> !abnormal);

  p_abn_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abnormal) |-> $past(evt_abn));

  p_up_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_up |=> count_up);

  p_dn_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_dn |=> count_down);

  p_up_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    count_up |-> $past(evt_up));
endmodule

bind aqd_decoder aqd_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_mode   (in_mode),
  .abn_clr   (abn_clr),
  .evt_up    (evt_up),
  .evt_dn    (evt_dn),
  .evt_abn   (evt_abn),
  .count_up  (count_up),
  .count_down(count_down),
  .abnormal  (abnormal)
);

// File: tb/aqd_decoder_tb.sv
`timescale 1ns/1ps
module aqd_decoder_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_a = 1'b0, line_b = 1'b0;
  logic [1:0] in_mode = 2'd0, rate_sel = 2'd2;
  logic dir_inv = 1'b0, abn_clr = 1'b0;
  logic count_up, count_down, abnormal;

  int total = 0, bad = 0;
  int up_seen = 0, dn_seen = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  aqd_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .line_a(line_a), .line_b(line_b),
    .in_mode(in_mode), .rate_sel(rate_sel), .dir_inv(dir_inv),
    .abn_clr(abn_clr), .count_up(count_up), .count_down(count_down),
    .abnormal(abnormal)
  );

  always @(negedge clk) begin
    if (count_up)   up_seen++;
    if (count_down) dn_seen++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input logic [1:0] v);
    @(negedge clk);
    line_a = v[1];
    line_b = v[0];
    repeat (5) @(negedge clk);
  endtask

  task automatic clear_flag();
    @(negedge clk);
    abn_clr = 1'b1;
    @(negedge clk);
    abn_clr = 1'b0;
  endtask

  // position of a pair along the up-counting cycle 00,10,11,01
  function automatic int pos(input logic [1:0] v);
    case (v)
      2'b00: return 0;
      2'b10: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  // returns {up, dn, abn}
  function automatic logic [2:0] expect3(input int m, input int r, input int inv,
                                         input logic [1:0] p, input logic [1:0] c);
    int u, d, a, diff;
    u = 0; d = 0; a = 0;
    if (m == 0) begin
      diff = (pos(c) - pos(p) + 4) % 4;
      if (diff == 2) a = 1;
      else if (diff != 0) begin
        bit take;
        if (r >= 2)      take = 1;
        else if (r == 1) take = (p[1] != c[1]);
        else             take = (p[1] != c[1]) && (c[0] == 1'b0);
        if (take) begin
          if (diff == 1) u = 1; else d = 1;
        end
      end
    end else if (m == 1) begin
      if (c[0]) begin
        if (p[1] == 1'b0 && c[1] == 1'b1) u = 1;
        if (r != 0 && p[1] == 1'b1 && c[1] == 1'b0) u = 1;
      end
    end else begin
      int ru, rd;
      ru = (p[1] == 1'b0 && c[1] == 1'b1) ? 1 : 0;
      rd = (p[0] == 1'b0 && c[0] == 1'b1) ? 1 : 0;
      if (ru + rd == 1) begin u = ru; d = rd; end
    end
    if (inv != 0) return {d[0], u[0], a[0]};
    return {u[0], d[0], a[0]};
  endfunction

  function automatic string tag(input int m, input int r, input int inv, input bit a);
    if (inv != 0) return "R9";
    if (a) return "R5";
    if (m == 1) return "R7";
    if (m == 2) return "R8";
    if (r == 0) return "R4";
    if (r == 1) return "R3";
    return "R2";
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int u0, d0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R1 reset state
    chk(count_up == 0 && count_down == 0, "R1 strobes", up_seen + dn_seen, 0);
    chk(abnormal == 0, "R1 flag", int'(abnormal), 0);
    chk(up_seen == 0 && dn_seen == 0, "R1 idle", up_seen + dn_seen, 0);

    // R10 latency and width, every-edge quadrature
    in_mode = 2'd0; rate_sel = 2'd2; dir_inv = 1'b0;
    @(negedge clk);
    line_a = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    chk(count_up == 0, "R10 early", int'(count_up), 0);
    @(posedge clk); #1;
    chk(count_up == 1, "R10 on time", int'(count_up), 1);
    @(posedge clk); #1;
    chk(count_up == 0, "R10 width", int'(count_up), 0);
    put(2'b00);

    // R6 sticky then cleared
    clear_flag();
    put(2'b11);
    chk(abnormal == 1, "R6 set", int'(abnormal), 1);
    put(2'b10);
    chk(abnormal == 1, "R6 sticky", int'(abnormal), 1);
    clear_flag();
    @(negedge clk);
    chk(abnormal == 0, "R6 clear", int'(abnormal), 0);
    put(2'b00);

    // full sweep over modes, rates, polarity and every old/new pair
    for (int m = 0; m < 3; m++) begin
      for (int r = 0; r < 3; r++) begin
        for (int inv = 0; inv < 2; inv++) begin
          in_mode = 2'(m); rate_sel = 2'(r); dir_inv = inv[0];
          for (int p = 0; p < 4; p++) begin
            for (int c = 0; c < 4; c++) begin
              logic [2:0] e;
              string t;
              put(2'(p));
              clear_flag();
              @(negedge clk);
              u0 = up_seen; d0 = dn_seen;
              put(2'(c));
              e = expect3(m, r, inv, 2'(p), 2'(c));
              t = tag(m, r, inv, e[0]);
              chk((up_seen - u0) == int'(e[2]), t, up_seen - u0, int'(e[2]));
              chk((dn_seen - d0) == int'(e[1]), t, dn_seen - d0, int'(e[1]));
              chk(abnormal == e[0], t, int'(abnormal), int'(e[0]));
            end
          end
        end
      end
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule